// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block is the transmit half of an asynchronous serial port. Characters are pushed into a 16-entry byte queue. A serialiser drains the queue one character at a time and drives them onto a single line, which idles high. One external baud tick paces each bit. The frame format is taken from a mode word that can change at run time. That word selects 6, 7 or 8 data bits, one of five parity options and one or two stop bits. It can also route the serial stream to a loopback output that feeds the local receiver instead of the line.

A control word is presented together with a one-cycle write strobe. It carries single-bit commands:
- enable and disable the transmitter;
- flush the transmit logic;
- start a break;
- end a break.

The queue reports empty and full. Empty is asserted only when nothing is left to send and the final stop bit has fully elapsed. A surrounding driver can therefore use it to know that the line has really gone quiet.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_out` and `lb_out` are high, `tx_empty` is 1, `tx_full` is 0, and the transmitter is disabled.
- R2: A frame is a low start bit, then the data bits LSB first, then an optional parity bit, then high stop bits. Each bit is held from one baud tick to the next. `mode_val[2:1]` selects the character length: 00 gives 8 bits, 10 gives 7 bits, 11 gives 6 bits, and 01 is treated as 8 bits.
- R3: `mode_val[5:3]` selects parity over the transmitted data bits: 000 even, 001 odd, 010 always 0, 011 always 1, and 1xx sends no parity bit.
- R4: `mode_val[7]` = 1 sends two stop bits; 0 sends one.
- R5: A control write with bit 4 enables the transmitter, and one with bit 5 disables it. When both bits are set, disable wins. A disabled transmitter starts no new character, but a character already on the line completes.
- R6: A control write with bit 1 empties the queue and abandons any frame in progress. The line returns high and `tx_empty` is 1 at the next cycle. The enable state is kept.
- R7: A control write with bit 7 forces the line low continuously, starting the next cycle. A control write with bit 8 releases it, and bit 8 wins when both are set. No character is started while the break is held.
- R8: The queue holds 16 characters and `tx_full` is set when it is full. Writes made while it is full are discarded, and characters leave in write order.
- R9: `tx_empty` is 0 until the queue is drained and the last stop bit of the final character has ended.
- R10: With `mode_val[9:8]` = 10, the serial stream appears on `lb_out` and `tx_out` stays high. With any other value, `lb_out` stays high.
- R11: The format of a character is captured when its start bit begins. Changing `mode_val` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Character to queue (unused high bits ignored for short characters) |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| ctrl_wr | input | 1 | Control word strobe |
| ctrl_val | input | 9 | Control commands: 1 flush, 4 enable, 5 disable, 7 break on, 8 break off |
| mode_val | input | 10 | Frame format and loopback selection |
| tx_out | output | 1 | Serial line |
| lb_out | output | 1 | Loopback stream toward the local receiver |
| tx_empty | output | 1 | Queue drained and line idle |
| tx_full | output | 1 | Queue full |

## Verification
Two command pairs can land in the same control write: enable with disable, and break-on with break-off. In each case only one outcome may take effect.

The bench first queues data with the transmitter disabled. It then issues a single write carrying both enable and disable, and watches the line for several frame times. It expects no start bit and `tx_empty` still 0. A plain enable afterwards must then release the queued character intact.

Likewise, a write carrying both break bits must leave the line high. The character held back by the break must then be received correctly.

A disable issued in the middle of a frame is judged the same way. The bench checks that the current character completes and that the next one does not start.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int CHAR_MAX = 8;
    localparam int CNT_W    = $clog2(CHAR_MAX + 1);
    localparam int CTRL_W   = 9;
    localparam int MODE_W   = 10;

    // control word command bit positions
    localparam int CB_FLUSH   = 1;
    localparam int CB_ENABLE  = 4;
    localparam int CB_DISABLE = 5;
    localparam int CB_BRK_ON  = 7;
    localparam int CB_BRK_OFF = 8;

    typedef enum logic [1:0] {
        LEN8,
        LEN7,
        LEN6
    } char_len_e;

    typedef enum logic [2:0] {
        PAR_EVEN,
        PAR_ODD,
        PAR_ZERO,
        PAR_ONE,
        PAR_NONE
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } ser_state_e;

    typedef struct packed {
        char_len_e len;
        par_e      par;
        logic      two_stop;
        logic      loopback;
    } frame_cfg_t;

    typedef struct packed {
        logic flush;
        logic en;
        logic dis;
        logic brk_on;
        logic brk_off;
    } ctrl_cmd_t;

    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        frame_cfg_t c;
        case (m[2:1])
            2'b10:   c.len = LEN7;
            2'b11:   c.len = LEN6;
            default: c.len = LEN8;
        endcase
        if (m[5]) begin
            c.par = PAR_NONE;
        end else begin
            case (m[4:3])
                2'b00:   c.par = PAR_EVEN;
                2'b01:   c.par = PAR_ODD;
                2'b10:   c.par = PAR_ZERO;
                default: c.par = PAR_ONE;
            endcase
        end
        c.two_stop = m[7];
        c.loopback = (m[9:8] == 2'b10);
        return c;
    endfunction

    function automatic ctrl_cmd_t decode_ctrl(input logic wr, input logic [CTRL_W-1:0] v);
        ctrl_cmd_t k;
        k.flush   = wr & v[CB_FLUSH];
        k.en      = wr & v[CB_ENABLE];
        k.dis     = wr & v[CB_DISABLE];
        k.brk_on  = wr & v[CB_BRK_ON];
        k.brk_off = wr & v[CB_BRK_OFF];
        return k;
    endfunction

    function automatic logic [CNT_W-1:0] char_bits(input char_len_e l);
        case (l)
            LEN7:    return CNT_W'(7);
            LEN6:    return CNT_W'(6);
            default: return CNT_W'(8);
        endcase
    endfunction

    function automatic logic [CHAR_MAX-1:0] char_mask(input char_len_e l);
        logic [CHAR_MAX-1:0] mk;
        for (int i = 0; i < CHAR_MAX; i++) begin
            mk[i] = (i < int'(char_bits(l)));
        end
        return mk;
    endfunction

    function automatic logic calc_parity(input par_e p, input logic [CHAR_MAX-1:0] d,
                                         input char_len_e l);
        logic [CHAR_MAX-1:0] md;
        md = d & char_mask(l);
        case (p)
            PAR_EVEN: return ^md;
            PAR_ODD:  return ~(^md);
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uftx_fifo.sv
module uftx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= ptr_next(wp);
            if (do_pop)  rp <= ptr_next(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // R8
    fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (full && $stable(cnt)));

endmodule

// File: rtl/uftx_ctrl.sv
module uftx_ctrl
    import uftx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctrl_cmd_t cmd,
    output logic      tx_en,
    output logic      brk_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en  <= 1'b0;
            brk_on <= 1'b0;
        end else begin
            if (cmd.dis)      tx_en <= 1'b0;
            else if (cmd.en)  tx_en <= 1'b1;

            if (cmd.brk_off)     brk_on <= 1'b0;
            else if (cmd.brk_on) brk_on <= 1'b1;
        end
    end

    // R5
    dis_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.en && cmd.dis) |=> !tx_en);

    // R7
    brk_off_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.brk_on && cmd.brk_off) |=> !brk_on);

endmodule

// File: rtl/uftx_serializer.sv
module uftx_serializer
    import uftx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                abort,
    input  logic                tick,
    input  logic                can_start,
    input  logic [CHAR_MAX-1:0] din,
    input  frame_cfg_t          cfg,
    output logic                pop,
    output logic                busy,
    output logic                line
);
    ser_state_e          state;
    frame_cfg_t          cfg_q;
    logic [CHAR_MAX-1:0] sh;
    logic [CNT_W-1:0]    cnt;
    logic                par_q;
    logic                stop_done, last_data, start_now;

    assign last_data = (cnt == char_bits(cfg_q.len) - 1'b1);
    assign stop_done = (state == ST_STOP) && (!cfg_q.two_stop || cnt[0]);
    assign start_now = tick && can_start && !abort &&
                       ((state == ST_IDLE) || stop_done);
    assign pop  = start_now;
    assign busy = (state != ST_IDLE);

    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = sh[0];
            ST_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            par_q <= 1'b0;
            cfg_q <= '{len: LEN8, par: PAR_NONE, two_stop: 1'b0, loopback: 1'b0};
        end else if (start_now) begin
            state <= ST_START;
            cnt   <= '0;
            sh    <= din;
            cfg_q <= cfg;
            par_q <= calc_parity(cfg.par, din, cfg.len);
        end else if (tick) begin
            case (state)
                ST_START: begin
                    state <= ST_DATA;
                    cnt   <= '0;
                end
                ST_DATA: begin
                    sh <= sh >> 1;
                    if (last_data) begin
                        state <= (cfg_q.par == PAR_NONE) ? ST_STOP : ST_PAR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    state <= ST_STOP;
                    cnt   <= '0;
                end
                ST_STOP: begin
                    if (stop_done) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !abort) |=> ($stable(state) && $stable(line)));

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && line));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CHAR_MAX-1:0] wr_data,
    input  logic                baud_tick,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_val,
    input  logic [MODE_W-1:0]   mode_val,
    output logic                tx_out,
    output logic                lb_out,
    output logic                tx_empty,
    output logic                tx_full
);
    ctrl_cmd_t           cmd;
    frame_cfg_t          cfg;
    logic                tx_en, brk_on;
    logic                fifo_empty, pop, busy, ser_line, serial;
    logic [CHAR_MAX-1:0] head;

    assign cmd = decode_ctrl(ctrl_wr, ctrl_val);
    assign cfg = decode_mode(mode_val);

    uftx_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .tx_en  (tx_en),
        .brk_on (brk_on)
    );

    uftx_fifo #(
        .WIDTH (CHAR_MAX),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (cmd.flush),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (tx_full)
    );

    uftx_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .abort     (cmd.flush),
        .tick      (baud_tick),
        .can_start (tx_en && !brk_on && !fifo_empty),
        .din       (head),
        .cfg       (cfg),
        .pop       (pop),
        .busy      (busy),
        .line      (ser_line)
    );

    assign serial   = ser_line & ~brk_on;
    assign tx_out   = cfg.loopback ? 1'b1 : serial;
    assign lb_out   = cfg.loopback ? serial : 1'b1;
    assign tx_empty = fifo_empty & ~busy;

    // R7
    brk_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
        brk_on |-> !pop);

    // R5
    dis_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !pop);

    // R8
    pop_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty);

    // R9
    empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> ($past(busy) || $past(cmd.flush)));

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

    localparam int P = 8;

    logic       clk, rst, wr_en, baud_tick, ctrl_wr;
    logic [7:0] wr_data;
    logic [8:0] ctrl_val;
    logic [9:0] mode_val;
    logic       tx_out, lb_out, tx_empty, tx_full;

    int  nchk = 0, nfail = 0;
    bit  finished = 0;
    bit  mode_swap = 0, hook_dis = 0, mon_tx = 0, tx_low_seen = 0;
    logic [9:0] swap_val;
    logic       last_stop_empty;

    uart_frame_tx dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .baud_tick (baud_tick),
        .ctrl_wr   (ctrl_wr),
        .ctrl_val  (ctrl_val),
        .mode_val  (mode_val),
        .tx_out    (tx_out),
        .lb_out    (lb_out),
        .tx_empty  (tx_empty),
        .tx_full   (tx_full)
    );

    initial begin
        clk = 0;
        forever #5 clk = ~clk;
    end

    initial begin
        baud_tick = 0;
        forever begin
            repeat (P - 1) @(negedge clk);
            baud_tick = 1;
            @(negedge clk);
            baud_tick = 0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (mon_tx && tx_out !== 1'b1) tx_low_seen = 1;
        end
    end

    function automatic logic [9:0] mk_mode(input logic [1:0] len, input logic [2:0] par,
                                           input bit two, input bit lb);
        return {(lb ? 2'b10 : 2'b00), two, 1'b0, par, len, 1'b0};
    endfunction

    function automatic logic exp_par(input logic [2:0] code, input logic [7:0] d);
        case (code)
            3'b000:  return ^d;
            3'b001:  return ~(^d);
            3'b010:  return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1;
        @(negedge clk);
        wr_en   = 0;
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        ctrl_val = v;
        ctrl_wr  = 1;
        @(negedge clk);
        ctrl_wr  = 0;
        ctrl_val = '0;
    endtask

    function automatic logic cur_line(input bit lb);
        return lb ? lb_out : tx_out;
    endfunction

    task automatic watch_level(input int n, input logic lvl, input bit lb, output bit ok);
        ok = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cur_line(lb) !== lvl) ok = 0;
        end
    endtask

    task automatic rx_frame(input int nb, input bit pen, input int nst, input bit lb,
                            output logic [7:0] d, output logic p, output bit ok);
        int guard;
        guard = 0;
        ok = 1;
        d  = '0;
        p  = 0;
        forever begin
            @(negedge clk);
            if (cur_line(lb) === 1'b0) break;
            guard++;
            if (guard > 4000) begin
                ok = 0;
                return;
            end
        end
        repeat (P / 2) @(negedge clk);
        if (cur_line(lb) !== 1'b0) ok = 0;
        if (mode_swap) begin
            mode_val  = swap_val;
            mode_swap = 0;
        end
        if (hook_dis) begin
            ctrl_val = 9'h020;
            ctrl_wr  = 1;
        end
        for (int i = 0; i < nb; i++) begin
            repeat (P) @(negedge clk);
            if (hook_dis) begin
                ctrl_wr  = 0;
                ctrl_val = '0;
                hook_dis = 0;
            end
            d[i] = cur_line(lb);
        end
        if (pen) begin
            repeat (P) @(negedge clk);
            p = cur_line(lb);
        end
        for (int i = 0; i < nst; i++) begin
            repeat (P) @(negedge clk);
            if (cur_line(lb) !== 1'b1) ok = 0;
            last_stop_empty = tx_empty;
        end
    endtask

    task automatic xfer(input logic [9:0] pm, input logic [9:0] dm, input logic [7:0] data,
                        input bit lb, input string req);
        int nb, nst;
        bit pen;
        logic [7:0] got, expd;
        logic gp;
        bit ok;
        nb  = (dm[2:1] == 2'b10) ? 7 : (dm[2:1] == 2'b11) ? 6 : 8;
        pen = !dm[5];
        nst = dm[7] ? 2 : 1;
        mode_val = pm;
        wr_byte(data);
        rx_frame(nb, pen, nst, lb, got, gp, ok);
        expd = data & 8'((1 << nb) - 1);
        chk({req, " data bits"}, got, expd);
        if (pen) chk({req, " parity bit"}, gp, exp_par(dm[5:3], expd));
        chk({req, " start/stop levels"}, ok, 1);
        chk("R9 empty low during last stop", last_stop_empty, 0);
        repeat (P) @(negedge clk);
        chk("R9 empty after last stop", tx_empty, 1);
    endtask

    task automatic t_reset;
        chk("R1 tx_out idle", tx_out, 1);
        chk("R1 lb_out idle", lb_out, 1);
        chk("R1 empty", tx_empty, 1);
        chk("R1 full", tx_full, 0);
    endtask

    task automatic t_full;
        bit ok;
        logic [7:0] got;
        logic gp;
        mode_val = mk_mode(2'b00, 3'b100, 0, 0);
        for (int i = 0; i < 16; i++) wr_byte(8'h10 + 8'(i));
        chk("R8 full after 16", tx_full, 1);
        wr_byte(8'hEE);
        watch_level(3 * P, 1'b1, 0, ok);
        chk("R1 disabled after reset, no frame", ok, 1);
        wr_ctrl(9'h010);
        for (int i = 0; i < 16; i++) begin
            rx_frame(8, 0, 1, 0, got, gp, ok);
            chk("R8 order", got, 8'h10 + 8'(i));
            chk("R8 frame levels", ok, 1);
        end
        repeat (P) @(negedge clk);
        chk("R8 queue drained", tx_empty, 1);
        watch_level(20 * P, 1'b1, 0, ok);
        chk("R8 write when full dropped", ok, 1);
    endtask

    task automatic t_formats;
        xfer(mk_mode(2'b00, 3'b100, 0, 0), mk_mode(2'b00, 3'b100, 0, 0), 8'hA5, 0, "R2 8N1");
        xfer(mk_mode(2'b10, 3'b000, 0, 0), mk_mode(2'b10, 3'b000, 0, 0), 8'hDA, 0, "R2 R3 7 even");
        xfer(mk_mode(2'b11, 3'b001, 1, 0), mk_mode(2'b11, 3'b001, 1, 0), 8'h2B, 0, "R3 R4 6 odd 2stop");
        xfer(mk_mode(2'b00, 3'b010, 0, 0), mk_mode(2'b00, 3'b010, 0, 0), 8'hFF, 0, "R3 space");
        xfer(mk_mode(2'b00, 3'b011, 1, 0), mk_mode(2'b00, 3'b011, 1, 0), 8'h00, 0, "R3 R4 mark");
    endtask

    task automatic t_enable;
        bit ok;
        logic [7:0] got;
        logic gp;
        mode_val = mk_mode(2'b00, 3'b100, 0, 0);
        wr_ctrl(9'h020);
        wr_byte(8'h81);
        wr_ctrl(9'h030);
        watch_level(4 * 10 * P, 1'b1, 0, ok);
        chk("R5 both bits: disable wins", ok, 1);
        chk("R5 queued char kept", tx_empty, 0);
        wr_byte(8'h42);
        hook_dis = 1;
        wr_ctrl(9'h010);
        rx_frame(8, 0, 1, 0, got, gp, ok);
        chk("R5 frame in progress completes", got, 8'h81);
        chk("R5 frame levels", ok, 1);
        watch_level(4 * 10 * P, 1'b1, 0, ok);
        chk("R5 no new start after disable", ok, 1);
        chk("R5 second char still queued", tx_empty, 0);
        wr_ctrl(9'h010);
        rx_frame(8, 0, 1, 0, got, gp, ok);
        chk("R5 resumes on enable", got, 8'h42);
    endtask

    task automatic t_flush;
        bit ok;
        int guard;
        mode_val = mk_mode(2'b00, 3'b100, 0, 0);
        wr_ctrl(9'h020);
        wr_byte(8'h11);
        wr_byte(8'h22);
        wr_byte(8'h33);
        wr_ctrl(9'h010);
        guard = 0;
        while (tx_out !== 1'b0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (P + 2) @(negedge clk);
        wr_ctrl(9'h002);
        chk("R6 line high after flush", tx_out, 1);
        chk("R6 empty after flush", tx_empty, 1);
        watch_level(30 * P, 1'b1, 0, ok);
        chk("R6 nothing left to send", ok, 1);
        xfer(mode_val, mode_val, 8'h6C, 0, "R6 enable kept");
    endtask

    task automatic t_break;
        bit ok;
        logic [7:0] got;
        logic gp;
        mode_val = mk_mode(2'b00, 3'b100, 0, 0);
        wr_ctrl(9'h080);
        chk("R7 line low on break", tx_out, 0);
        wr_byte(8'h3C);
        watch_level(5 * P, 1'b0, 0, ok);
        chk("R7 line held low", ok, 1);
        chk("R7 char not consumed", tx_empty, 0);
        wr_ctrl(9'h180);
        chk("R7 both bits: break released", tx_out, 1);
        rx_frame(8, 0, 1, 0, got, gp, ok);
        chk("R7 held char sent after break", got, 8'h3C);
        chk("R7 frame levels", ok, 1);
    endtask

    task automatic t_loop;
        tx_low_seen = 0;
        mon_tx = 1;
        xfer(mk_mode(2'b10, 3'b001, 0, 1), mk_mode(2'b10, 3'b001, 0, 1), 8'h5E, 1, "R10 loopback");
        mon_tx = 0;
        chk("R10 tx_out idle in loopback", tx_low_seen, 0);
        mode_val = mk_mode(2'b00, 3'b100, 0, 0);
        @(negedge clk);
        chk("R10 lb_out idle in normal mode", lb_out, 1);
    endtask

    task automatic t_snapshot;
        swap_val  = mk_mode(2'b11, 3'b001, 1, 0);
        mode_swap = 1;
        xfer(mk_mode(2'b00, 3'b100, 0, 0), mk_mode(2'b00, 3'b100, 0, 0), 8'hC3, 0, "R11 mid-frame mode change");
        mode_val = mk_mode(2'b00, 3'b100, 0, 0);
    endtask

    initial begin
        rst = 1; wr_en = 0; wr_data = '0; ctrl_wr = 0; ctrl_val = '0;
        mode_val = '0; last_stop_empty = 0; swap_val = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_full();
        t_formats();
        t_enable();
        t_flush();
        t_break();
        t_loop();
        t_snapshot();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule